// File: doc/BRIEF.md
# Overlaid Memory Region Decoder

This block turns a 16-bit memory address, a read or write strobe and the identity of the requester (the processor or a DMA master) into one chip select out of three memory regions: main RAM, display RAM and a small boot PROM. The map has two switchable overlays. The upper quarter of the address space (0xC000-0xFFFF) is either display memory or more program RAM. The lowest 2K (0x0000-0x07FF) can be covered by the boot PROM.

The PROM overlay applies to reads only. While it is active, a read in the low 2K is served by the PROM. A write to the same addresses still goes to the RAM underneath, so program RAM can be loaded while the PROM runs. Display memory belongs to the processor and the scan path alone. A DMA access that lands in the upper quarter while display memory is mapped gets no chip select, and the block raises a one-cycle rejection flag instead.

The two overlay controls are registered. Every select is combinational from those registered bits and the current access. After reset the display region is mapped and the PROM is not.

Top module: `memmap_decoder`

## Requirements
- R1: After reset, with the display control left high, a processor read or write at 0xC000-0xFFFF asserts only `sel_disp_ram`.
- R2: With the display control low (registered), processor and DMA accesses at 0xC000-0xFFFF assert only `sel_main_ram`.
- R3: Any access at 0x0800-0xBFFF asserts only `sel_main_ram`, whatever the overlay controls are. With the PROM overlay off, any access at 0x0000-0x07FF does the same.
- R4: With the PROM overlay on, a read (`rd_stb` high, from either requester) at 0x0000-0x07FF asserts only `sel_boot_rom`.
- R5: With the PROM overlay on, a write (`wr_stb` high, `rd_stb` low) at 0x0000-0x07FF asserts only `sel_main_ram`, never `sel_boot_rom`.
- R6: A DMA access (`req_is_dma` = 1) never asserts `sel_disp_ram`. A DMA access at 0xC000-0xFFFF while the display is mapped asserts no select at all.
- R7: `dma_reject` is high in the clock cycle that follows each DMA access rejected under R6, and low otherwise. Two rejected accesses back to back keep it high for two cycles.
- R8: At most one select is high at any time. Every processor access asserts exactly one select. With both strobes low, no select is high.
- R9: Both overlay controls take effect from the first clock edge at which they are sampled and may change between any two accesses. Reset maps the display region (control bit 1) and unmaps the PROM (control bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | input | 16 | Access address |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| req_is_dma | input | 1 | 1 = access from the DMA master, 0 = processor |
| disp_map_req | input | 1 | 1 = upper quarter is display memory, 0 = program RAM |
| boot_rom_req | input | 1 | 1 = PROM covers the low 2K for reads |
| sel_main_ram | output | 1 | Main RAM chip select |
| sel_disp_ram | output | 1 | Display RAM chip select |
| sel_boot_rom | output | 1 | Boot PROM chip select |
| dma_reject | output | 1 | One-cycle flag after a refused DMA access to display memory |

## Verification
The assertions check, on every cycle, the properties that depend only on the current access. They cover exclusivity and completeness of the selects, the rule that DMA never reaches display memory, the confinement of PROM selects to low-2K reads, and the cause-and-effect link between a refused DMA access and the flag in the next cycle. The bench scenarios are what show that each address boundary (0x07FF/0x0800, 0xBFFF/0xC000) lands on the right region under each overlay setting. They also show that a control change is seen one edge after it is sampled, and that the reset values of the overlays are correct.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  localparam int unsigned ADDR_W_DEF    = 16;
  localparam int unsigned TOP_BITS_DEF  = 2;   // upper quarter of the map
  localparam int unsigned ROM_LOG2_DEF  = 11;  // 2K PROM window
  localparam int unsigned SYNC_DEF      = 2;

  // control bit positions inside the registered control word
  localparam int unsigned CTRL_DISP = 0;
  localparam int unsigned CTRL_ROM  = 1;
  localparam int unsigned CTRL_N    = 2;
  localparam logic [CTRL_N-1:0] CTRL_RST_VAL = 2'b01; // display on, PROM off

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_MAIN,
    RGN_DISP,
    RGN_ROM,
    RGN_BLOCKED
  } region_e;

endpackage

// File: rtl/memmap_ctrl_regs.sv
module memmap_ctrl_regs #(
  parameter int unsigned NUM_BITS    = 2,
  parameter logic [NUM_BITS-1:0] RESET_VAL = '0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_BITS-1:0] ctrl_in,
  output logic [NUM_BITS-1:0] ctrl_q,
  output logic                rst_core_n
);

  // reset: asserted at once, released after SYNC_STAGES edges
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_core_n = sync_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_core_n = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  // one flop per control bit, each with its own reset value and enable
  generate
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
      logic bit_en;
      logic bit_nxt;
      logic bit_q;

      always_comb begin
        bit_en  = (ctrl_in[i] != bit_q);
        bit_nxt = bit_en ? ctrl_in[i] : bit_q;
      end

      always_ff @(posedge clk or negedge rst_core_n) begin
        if (!rst_core_n)  bit_q <= RESET_VAL[i];
        else if (bit_en)  bit_q <= bit_nxt;
      end

      assign ctrl_q[i] = bit_q;
    end
  endgenerate

endmodule

// File: rtl/memmap_region_class.sv
module memmap_region_class #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned TOP_BITS = 2,
  parameter int unsigned ROM_LOG2 = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_top,
  output logic              in_rom_win
);

  localparam int unsigned ROM_TAG_W = ADDR_W - ROM_LOG2;

  logic [TOP_BITS-1:0]  top_tag;
  logic [ROM_TAG_W-1:0] rom_tag;

  always_comb begin
    top_tag    = addr[ADDR_W-1 -: TOP_BITS];
    rom_tag    = addr[ADDR_W-1 -: ROM_TAG_W];
    in_top     = &top_tag;
    in_rom_win = ~|rom_tag;
  end

endmodule

// File: rtl/memmap_select_logic.sv
module memmap_select_logic
  import memmap_pkg::*;
(
  input  logic rd,
  input  logic wr,
  input  logic from_dma,
  input  logic in_top,
  input  logic in_rom_win,
  input  logic disp_mapped,
  input  logic rom_mapped,
  output logic sel_main,
  output logic sel_disp,
  output logic sel_rom,
  output logic reject_nxt
);

  region_e rgn;
  logic    access;

  always_comb begin
    access = rd | wr;
    rgn    = RGN_NONE;
    if (access) begin
      if (in_top && disp_mapped) begin
        rgn = from_dma ? RGN_BLOCKED : RGN_DISP;
      end else if (in_rom_win && rom_mapped && rd) begin
        rgn = RGN_ROM;
      end else begin
        rgn = RGN_MAIN;
      end
    end
  end

  always_comb begin
    sel_main   = (rgn == RGN_MAIN);
    sel_disp   = (rgn == RGN_DISP);
    sel_rom    = (rgn == RGN_ROM);
    reject_nxt = (rgn == RGN_BLOCKED);
  end

endmodule

// File: rtl/memmap_reject_reg.sv
module memmap_reject_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic reject_nxt,
  output logic reject_q
);

  logic upd_en;
  logic flag_nxt;

  always_comb begin
    upd_en   = reject_nxt | reject_q;
    flag_nxt = reject_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reject_q <= 1'b0;
    else if (upd_en) reject_q <= flag_nxt;
  end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned TOP_BITS    = TOP_BITS_DEF,
  parameter int unsigned ROM_LOG2    = ROM_LOG2_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              req_is_dma,
  input  logic              disp_map_req,
  input  logic              boot_rom_req,
  output logic              sel_main_ram,
  output logic              sel_disp_ram,
  output logic              sel_boot_rom,
  output logic              dma_reject
);

  logic [CTRL_N-1:0] ctrl_in;
  logic [CTRL_N-1:0] ctrl_q;
  logic              rst_core_n;
  logic              in_top;
  logic              in_rom_win;
  logic              reject_nxt;

  always_comb begin
    ctrl_in            = '0;
    ctrl_in[CTRL_DISP] = disp_map_req;
    ctrl_in[CTRL_ROM]  = boot_rom_req;
  end

  memmap_ctrl_regs #(
    .NUM_BITS   (CTRL_N),
    .RESET_VAL  (CTRL_RST_VAL),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_in   (ctrl_in),
    .ctrl_q    (ctrl_q),
    .rst_core_n(rst_core_n)
  );

  memmap_region_class #(
    .ADDR_W  (ADDR_W),
    .TOP_BITS(TOP_BITS),
    .ROM_LOG2(ROM_LOG2)
  ) u_class (
    .addr      (mem_addr),
    .in_top    (in_top),
    .in_rom_win(in_rom_win)
  );

  memmap_select_logic u_sel (
    .rd         (rd_stb),
    .wr         (wr_stb),
    .from_dma   (req_is_dma),
    .in_top     (in_top),
    .in_rom_win (in_rom_win),
    .disp_mapped(ctrl_q[CTRL_DISP]),
    .rom_mapped (ctrl_q[CTRL_ROM]),
    .sel_main   (sel_main_ram),
    .sel_disp   (sel_disp_ram),
    .sel_rom    (sel_boot_rom),
    .reject_nxt (reject_nxt)
  );

  memmap_reject_reg u_rej (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .reject_nxt(reject_nxt),
    .reject_q  (dma_reject)
  );

endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned TOP_BITS = 2,
  parameter int unsigned ROM_LOG2 = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              req_is_dma,
  input logic              sel_main_ram,
  input logic              sel_disp_ram,
  input logic              sel_boot_rom,
  input logic              dma_reject
);

  logic       acc;
  logic       top;
  logic       low;
  logic [2:0] sels;

  always_comb begin
    acc  = rd_stb | wr_stb;
    top  = (mem_addr[ADDR_W-1 -: TOP_BITS] == '1);
    low  = ((mem_addr >> ROM_LOG2) == '0);
    sels = {sel_main_ram, sel_disp_ram, sel_boot_rom};
  end

  a_r1_disp_only_top: assert property (@(posedge clk) disable iff (!rst_n)
    sel_disp_ram |-> (top && acc));

  a_r6_dma_no_disp: assert property (@(posedge clk) disable iff (!rst_n)
    req_is_dma |-> !sel_disp_ram);

  a_r4_rom_read_low: assert property (@(posedge clk) disable iff (!rst_n)
    sel_boot_rom |-> (rd_stb && low));

  a_r5_write_not_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_stb) |-> !sel_boot_rom);

  a_r8_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sels));

  a_r8_cpu_one: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_is_dma) |-> $onehot(sels));

  a_r8_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> (sels == 3'b000));

  a_r7_reject_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_is_dma && acc && top && !sel_main_ram) |=> dma_reject);

  a_r7_reject_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dma_reject |-> $past(req_is_dma && acc && top && (sels == 3'b000)));

endmodule

bind memmap_decoder memmap_decoder_chk #(
  .ADDR_W  (ADDR_W),
  .TOP_BITS(TOP_BITS),
  .ROM_LOG2(ROM_LOG2)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .mem_addr    (mem_addr),
  .rd_stb      (rd_stb),
  .wr_stb      (wr_stb),
  .req_is_dma  (req_is_dma),
  .sel_main_ram(sel_main_ram),
  .sel_disp_ram(sel_disp_ram),
  .sel_boot_rom(sel_boot_rom),
  .dma_reject  (dma_reject)
);

// File: tb/memmap_decoder_tb_top.sv
module memmap_decoder_tb_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic        rd_stb;
  logic        wr_stb;
  logic        req_is_dma;
  logic        disp_map_req;
  logic        boot_rom_req;
  logic        sel_main_ram;
  logic        sel_disp_ram;
  logic        sel_boot_rom;
  logic        dma_reject;

  int checks;
  int fails;
  bit done;

  memmap_decoder dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_addr    (mem_addr),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .req_is_dma  (req_is_dma),
    .disp_map_req(disp_map_req),
    .boot_rom_req(boot_rom_req),
    .sel_main_ram(sel_main_ram),
    .sel_disp_ram(sel_disp_ram),
    .sel_boot_rom(sel_boot_rom),
    .dma_reject  (dma_reject)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: controls, requester, strobes, address, expected {main,disp,rom}, reject
  typedef struct packed {
    logic        disp;
    logic        rom;
    logic        dma;
    logic        rd;
    logic        wr;
    logic [15:0] addr;
    logic [2:0]  exp_sel;
    logic        exp_rej;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'hC000, 3'b010, 1'b0, 4'd1},  // R1 read
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFF, 3'b010, 1'b0, 4'd1},  // R1 write
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'hBFFF, 3'b100, 1'b0, 4'd3},  // R3 edge
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 3'b100, 1'b0, 4'd3},  // R3 PROM off
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 3'b001, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h07FF, 3'b001, 1'b0, 4'd4},  // R4 edge
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0800, 3'b100, 1'b0, 4'd3},  // R3 above window
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0100, 3'b100, 1'b0, 4'd5},  // R5
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'hC000, 3'b100, 1'b0, 4'd2},  // R2 read
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'hE123, 3'b100, 1'b0, 4'd2},  // R2 write
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'hC000, 3'b000, 1'b1, 4'd6},  // R6/R7 read
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFF, 3'b000, 1'b1, 4'd7},  // R7 write
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'hC000, 3'b100, 1'b0, 4'd2},  // R2 DMA
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0010, 3'b001, 1'b0, 4'd4},  // R4 DMA
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h4000, 3'b100, 1'b0, 4'd3},  // R3 DMA
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC000, 3'b000, 1'b0, 4'd8}   // R8 idle
  };

  task automatic chk(input string req, input string what, input logic [3:0] act,
                     input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] selv();
    return {1'b0, sel_main_ram, sel_disp_ram, sel_boot_rom};
  endfunction

  task automatic idle_bus();
    rd_stb = 1'b0; wr_stb = 1'b0; req_is_dma = 1'b0; mem_addr = 16'h0000;
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0;
    idle_bus();
    disp_map_req = 1'b1; boot_rom_req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "reset selects", selv(), 4'b0000);
    chk("R7", "reset reject", {3'b0, dma_reject}, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R9: reset mapping visible
    @(negedge clk);
    rd_stb = 1'b1; mem_addr = 16'hC004;
    #1 chk("R9", "reset display mapped", selv(), 4'b0010);
    mem_addr = 16'h0004;
    #1 chk("R9", "reset PROM unmapped", selv(), 4'b0100);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle_bus();
      disp_map_req = VECS[i].disp; boot_rom_req = VECS[i].rom;
      @(negedge clk);
      req_is_dma = VECS[i].dma; rd_stb = VECS[i].rd; wr_stb = VECS[i].wr;
      mem_addr = VECS[i].addr;
      #1 chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d selects", i),
             selv(), {1'b0, VECS[i].exp_sel});
      @(posedge clk);
      #1 chk(VECS[i].exp_rej ? "R7" : "R6", $sformatf("vec %0d reject", i),
             {3'b0, dma_reject}, {3'b0, VECS[i].exp_rej});
    end

    // R9: display control change seen one edge later
    @(negedge clk);
    idle_bus(); disp_map_req = 1'b1; boot_rom_req = 1'b0;
    @(negedge clk);
    rd_stb = 1'b1; mem_addr = 16'hD000; disp_map_req = 1'b0;
    #1 chk("R9", "display before edge", selv(), 4'b0010);
    @(posedge clk);
    #1 chk("R9", "display after edge", selv(), 4'b0100);

    // R9: PROM control change mid-access sequence
    @(negedge clk);
    mem_addr = 16'h0200; boot_rom_req = 1'b1;
    #1 chk("R9", "PROM before edge", selv(), 4'b0100);
    @(posedge clk);
    #1 chk("R9", "PROM after edge", selv(), 4'b0001);
    @(negedge clk);
    boot_rom_req = 1'b0;
    @(posedge clk);
    #1 chk("R9", "PROM removed", selv(), 4'b0100);

    // R7: back-to-back rejected DMA, then a clean cycle
    @(negedge clk);
    idle_bus(); disp_map_req = 1'b1;
    @(negedge clk);
    req_is_dma = 1'b1; rd_stb = 1'b1; mem_addr = 16'hC100;
    @(posedge clk);
    #1 chk("R7", "reject first", {3'b0, dma_reject}, 4'b0001);
    @(negedge clk); mem_addr = 16'hF000; rd_stb = 1'b0; wr_stb = 1'b1;
    #1 chk("R6", "DMA write top no select", selv(), 4'b0000);
    @(posedge clk);
    #1 chk("R7", "reject second", {3'b0, dma_reject}, 4'b0001);
    @(negedge clk); mem_addr = 16'h2000;
    @(posedge clk);
    #1 chk("R7", "reject drops", {3'b0, dma_reject}, 4'b0000);

    // R5/R8: PROM on, write at window edge and idle with PROM address
    @(negedge clk);
    idle_bus(); boot_rom_req = 1'b1;
    @(negedge clk);
    wr_stb = 1'b1; mem_addr = 16'h07FF;
    #1 chk("R5", "write at window top", selv(), 4'b0100);
    wr_stb = 1'b0;
    #1 chk("R8", "idle in PROM window", selv(), 4'b0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule